// File: doc/BRIEF.md
# I2C Memory Transaction Sequencer

This block runs whole register and memory transfers on a two-wire bus slave. It does so by issuing byte-level commands to a separate bit engine (START, STOP, byte write, byte read, bus recovery) and waiting for each one to complete. A host starts an operation with a 7-bit device address, a memory address of up to `ADDR_BYTES` bytes, an address length from 0 to `ADDR_BYTES`, a byte count and an operation code. Write data comes in over a valid/ready byte stream, and read data goes out over another.

There are three operations. A probe checks whether a device answers its address. A read first sets the slave's internal pointer with an address write. It then closes that phase with a full STOP and opens the read phase with a fresh START. A write sends the address and then streams data bytes. When a read or write is asked for with a nonzero fold mask, the memory-address bits above the transmitted address bytes are masked and ORed into the device address. This lets a small EEPROM that spreads its upper address bits across several device addresses be reached as one linear space. A pulse on the recovery input, while the block is idle, asks the engine to clock a stuck bus free.

Top module: `i2c_mem_seq`

## Requirements
- R1: A probe (op=0) issues START, then a byte write of {chip,0}, then STOP. It finishes with status 0 when that byte is acknowledged and status 1 when it is not.
- R2: For a read (op=1) with address length above zero, and for any write (op=2), the first byte after START is {chip,0}. If that byte is not acknowledged, the block issues STOP and ends with status 1.
- R3: Memory address bytes follow the device byte, most significant first. The number of bytes equals the address length (0 to 4).
- R4: If any memory address byte is not acknowledged, the block issues STOP at once and ends with status 2.
- R5: A read with address length above zero issues STOP, then START, then {chip,1} after its last address byte.
- R6: A read with address length 0 issues START and then {chip,1} directly, with no write phase.
- R7: Every byte read asks for an acknowledge, except the last of the count, which is flagged `eng_rd_last` (not acknowledged). STOP follows the last byte.
- R8: A write sends every data byte even if some are not acknowledged. `nack_cnt` reports how many were not acknowledged once the final STOP completes, with status 0.
- R9: The device byte uses chip | ((mem_addr >> 8*addr_len) & fold_mask). For example, with length 1 and mask 3, address 0x2A7 on chip 0x50 goes out as device 0x52 with address byte 0xA7.
- R10: A pulse on `init_req` while idle issues exactly one recovery command (code 0). The block is then idle again without a `done` pulse.
- R11: Write bytes are taken in order, one for each `wr_valid`/`wr_ready` handshake. Read bytes are offered on `rd_valid` and held stable until `rd_ready`.
- R12: After reset the block is idle with no command pending. Each operation ends with a one-cycle `done`. Status codes are 0 for OK, 1 for device not responding and 2 for address not acknowledged; code 3 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| init_req | input | 1 | Bus recovery request |
| start | input | 1 | Launch operation when idle |
| op | input | 2 | 0 probe, 1 read, 2 write |
| chip | input | 7 | Device address |
| mem_addr | input | 32 | Memory address |
| addr_len | input | 3 | Address bytes to send (0..4) |
| byte_cnt | input | 8 | Data bytes to move |
| fold_mask | input | 7 | Mask for folding upper address bits into the device address |
| busy | output | 1 | Operation or recovery in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | Result code |
| nack_cnt | output | 8 | Unacknowledged write data bytes |
| wr_valid | input | 1 | Write byte available |
| wr_data | input | 8 | Write byte |
| wr_ready | output | 1 | Write byte accepted |
| rd_valid | output | 1 | Read byte available |
| rd_data | output | 8 | Read byte |
| rd_ready | input | 1 | Read byte taken |
| eng_cmd_valid | output | 1 | Command to bit engine, held until done |
| eng_cmd | output | 3 | 0 recover, 1 start, 2 stop, 3 write, 4 read |
| eng_wdata | output | 8 | Byte for write command |
| eng_rd_last | output | 1 | Read command ends with no acknowledge |
| eng_done | input | 1 | Engine finished the command |
| eng_nack | input | 1 | Written byte was not acknowledged |
| eng_rdata | input | 8 | Byte returned by a read command |

## Verification
The hardest case to reach is a write in which some data bytes are refused while the transfer carries on. Another is a fold in which the device address seen on the bus differs from the one the host gave. The bench's slave model refuses writes into one 16-byte protected window, so a burst that crosses the window edge gives a known partial NACK count, and a read-back of the same range shows the refused bytes unchanged. Folding is reached by writing through a masked high address and reading the byte back through the plain device address it maps to.

// File: rtl/i2c_mem_seq.sv
module i2c_mem_seq #(
  parameter int ADDR_BYTES = 4,
  localparam int AW = 8 * ADDR_BYTES,
  localparam int LW = $clog2(ADDR_BYTES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          init_req,
  input  logic          start,
  input  logic [1:0]    op,
  input  logic [6:0]    chip,
  input  logic [AW-1:0] mem_addr,
  input  logic [LW-1:0] addr_len,
  input  logic [7:0]    byte_cnt,
  input  logic [6:0]    fold_mask,
  output logic          busy,
  output logic          done,
  output logic [1:0]    status,
  output logic [7:0]    nack_cnt,
  input  logic          wr_valid,
  input  logic [7:0]    wr_data,
  output logic          wr_ready,
  output logic          rd_valid,
  output logic [7:0]    rd_data,
  input  logic          rd_ready,
  output logic          eng_cmd_valid,
  output logic [2:0]    eng_cmd,
  output logic [7:0]    eng_wdata,
  output logic          eng_rd_last,
  input  logic          eng_done,
  input  logic          eng_nack,
  input  logic [7:0]    eng_rdata
);
  localparam logic [2:0] C_RECOV = 3'd0, C_START = 3'd1, C_STOP = 3'd2, C_WR = 3'd3, C_RD = 3'd4;
  localparam logic [1:0] OP_PROBE = 2'd0, OP_READ = 2'd1, OP_WRITE = 2'd2;
  localparam logic [1:0] ST_OK = 2'd0, ST_NODEV = 2'd1, ST_ADDR = 2'd2;

  typedef enum logic [3:0] {
    S_IDLE, S_RECOV, S_START, S_CHIPW, S_ADDR, S_MIDSTOP, S_RESTART,
    S_CHIPR, S_RDCMD, S_RDOUT, S_WRWAIT, S_WRCMD, S_STOP
  } st_t;

  st_t           state;
  logic [1:0]    op_q;
  logic [6:0]    chip_q;
  logic [AW-1:0] addr_q;
  logic [LW-1:0] alen_q, abyte;
  logic [7:0]    cnt_q, data_q;
  logic [AW+7:0] hi_bits;

  assign hi_bits  = {8'h00, mem_addr} >> {addr_len, 3'b000};
  assign busy     = state != S_IDLE;
  assign rd_valid = state == S_RDOUT;
  assign rd_data  = data_q;
  assign wr_ready = state == S_WRWAIT;
  assign eng_rd_last = state == S_RDCMD && cnt_q == 8'd1;
  assign eng_cmd_valid = !(state inside {S_IDLE, S_RDOUT, S_WRWAIT});

  always_comb begin
    eng_cmd   = C_STOP;
    eng_wdata = 8'h00;
    case (state)
      S_RECOV:             eng_cmd = C_RECOV;
      S_START, S_RESTART:  eng_cmd = C_START;
      S_CHIPW:   begin eng_cmd = C_WR; eng_wdata = {chip_q, 1'b0}; end
      S_CHIPR:   begin eng_cmd = C_WR; eng_wdata = {chip_q, 1'b1}; end
      S_ADDR:    begin eng_cmd = C_WR; eng_wdata = 8'(addr_q >> {abyte - 1'b1, 3'b000}); end
      S_WRCMD:   begin eng_cmd = C_WR; eng_wdata = data_q; end
      S_RDCMD:   eng_cmd = C_RD;
      default:   eng_cmd = C_STOP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; op_q <= OP_PROBE; chip_q <= '0; addr_q <= '0; alen_q <= '0;
      abyte <= '0; cnt_q <= '0; data_q <= '0; done <= 1'b0; status <= ST_OK; nack_cnt <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE:
          if (init_req) state <= S_RECOV;
          else if (start && op != 2'd3) begin
            op_q <= op; addr_q <= mem_addr; alen_q <= addr_len; cnt_q <= byte_cnt;
            chip_q <= chip | (hi_bits[6:0] & fold_mask);
            status <= ST_OK; nack_cnt <= '0; state <= S_START;
          end
        S_RECOV: if (eng_done) state <= S_IDLE;
        S_START: if (eng_done) state <= (op_q == OP_READ && alen_q == '0) ? S_CHIPR : S_CHIPW;
        S_CHIPW:
          if (eng_done) begin
            if (eng_nack) begin status <= ST_NODEV; state <= S_STOP; end
            else if (op_q == OP_PROBE) state <= S_STOP;
            else if (alen_q != '0) begin abyte <= alen_q; state <= S_ADDR; end
            else state <= (cnt_q == 8'd0) ? S_STOP : S_WRWAIT;
          end
        S_ADDR:
          if (eng_done) begin
            if (eng_nack) begin status <= ST_ADDR; state <= S_STOP; end
            else if (abyte == LW'(1))
              state <= (op_q == OP_READ) ? S_MIDSTOP : ((cnt_q == 8'd0) ? S_STOP : S_WRWAIT);
            else abyte <= abyte - 1'b1;
          end
        S_MIDSTOP: if (eng_done) state <= S_RESTART;
        S_RESTART: if (eng_done) state <= S_CHIPR;
        S_CHIPR:   if (eng_done) state <= (cnt_q == 8'd0) ? S_STOP : S_RDCMD;
        S_RDCMD:   if (eng_done) begin data_q <= eng_rdata; state <= S_RDOUT; end
        S_RDOUT:
          if (rd_ready) begin
            cnt_q <= cnt_q - 1'b1;
            state <= (cnt_q == 8'd1) ? S_STOP : S_RDCMD;
          end
        S_WRWAIT:  if (wr_valid) begin data_q <= wr_data; state <= S_WRCMD; end
        S_WRCMD:
          if (eng_done) begin
            if (eng_nack) nack_cnt <= nack_cnt + 1'b1;
            cnt_q <= cnt_q - 1'b1;
            state <= (cnt_q == 8'd1) ? S_STOP : S_WRWAIT;
          end
        S_STOP:    if (eng_done) begin state <= S_IDLE; done <= 1'b1; end
        default:   state <= S_IDLE;
      endcase
    end
  end

  a_r10_init_recover: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && init_req) |=> (eng_cmd_valid && eng_cmd == C_RECOV));
  a_r11_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));
  a_r11_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ready && !wr_valid) |=> wr_ready);
  a_r12_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_cmd_valid && !eng_done) |=> (eng_cmd_valid && $stable(eng_cmd) && $stable(eng_wdata)));
  a_r12_status_code: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (status != 2'd3 && !busy));
endmodule

// File: tb/tb_i2c_mem_seq.sv
module tb_i2c_mem_seq;
  logic clk = 0, rst_n = 0;
  logic init_req = 0, start = 0;
  logic [1:0] op = 0;
  logic [6:0] chip = 0, fold_mask = 0;
  logic [31:0] mem_addr = 0;
  logic [2:0] addr_len = 0;
  logic [7:0] byte_cnt = 0;
  logic busy, done, wr_ready, rd_valid, eng_cmd_valid, eng_rd_last;
  logic [1:0] status;
  logic [7:0] nack_cnt, rd_data, eng_wdata;
  logic [2:0] eng_cmd;
  logic wr_valid = 0, rd_ready = 0;
  logic [7:0] wr_data = 0;
  logic eng_done = 0, eng_nack = 0;
  logic [7:0] eng_rdata = 0;

  i2c_mem_seq dut (.*);

  always #10 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  string cur_req = "R12";
  logic [11:0] exq[$];
  logic [7:0] wq[$], rdq[$], wbuf[$], rexp[$];
  logic tog = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
      finish_run();
    end
  end

  // slave EEPROM model: device 0x50..0x53, 1 KiB, protected window 0xD0-0xDF per page,
  // address bytes >= 0xE0 refused
  logic [7:0] mem [0:1023];
  int sl_st = 0, sl_left = 0, dev_alen = 1;
  logic [1:0] page = 0;
  logic [9:0] ptr = 0;
  initial for (int i = 0; i < 1024; i++) mem[i] = 8'(i) ^ 8'h3C;

  bit e_busy = 0;
  int e_cnt = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      eng_done <= 0; e_busy = 0;
    end else if (eng_done) eng_done <= 0;
    else if (e_busy) begin
      if (e_cnt == 0) begin eng_done <= 1; e_busy = 0; end
      else e_cnt--;
    end else if (eng_cmd_valid) begin
      logic [11:0] got, want;
      logic [7:0] b;
      bit nk;
      b = eng_wdata;
      got = {eng_cmd, (eng_cmd == 3'd4) ? eng_rd_last : 1'b0, (eng_cmd == 3'd3) ? b : 8'h00};
      if (exq.size() == 0) chk(0, cur_req, "unexpected command", got, 0);
      else begin
        want = exq.pop_front();
        chk(got == want, cur_req, "engine command {cmd,last,byte}", got, want);
      end
      nk = 0;
      case (eng_cmd)
        3'd0, 3'd2: sl_st = 0;
        3'd1: sl_st = 1;
        3'd3: case (sl_st)
          1: if (b[7:3] == 5'b10100) begin
               page = b[2:1];
               if (b[0]) begin sl_st = 4; ptr[9:8] = page; end
               else if (dev_alen > 0) begin sl_st = 2; sl_left = dev_alen; end
               else sl_st = 3;
             end else begin nk = 1; sl_st = 0; end
          2: if (b >= 8'hE0) begin nk = 1; sl_st = 0; end
             else begin ptr = {page, b}; sl_left--; if (sl_left == 0) sl_st = 3; end
          3: begin if (ptr[7:4] == 4'hD) nk = 1; else mem[ptr] = b; ptr++; end
          default: nk = 1;
        endcase
        3'd4: begin eng_rdata <= mem[ptr]; ptr++; end
        default: ;
      endcase
      eng_nack <= nk;
      e_busy = 1; e_cnt = 2;
    end
  end

  always @(negedge clk) begin
    tog = ~tog;
    wr_valid = (wq.size() > 0) && tog;
    wr_data = (wq.size() > 0) ? wq[0] : 8'h00;
    rd_ready = ~tog;
  end
  always @(posedge clk) begin
    if (wr_valid && wr_ready) void'(wq.pop_front());
    if (rd_valid && rd_ready) rdq.push_back(rd_data);
  end

  function automatic logic [11:0] wcmd(input logic [7:0] b); return {3'd3, 1'b0, b}; endfunction

  task automatic run(input logic [1:0] o, input logic [6:0] c, input logic [31:0] a,
                     input int al, input int n, input logic [6:0] m,
                     input int exp_nack, input string req);
    logic [6:0] eff;
    int est;
    logic [7:0] ab;
    bit stopped;
    cur_req = req;
    eff = c | (7'(64'(a) >> (8 * al)) & m);
    est = 0; stopped = 0;
    exq.delete(); rdq.delete(); wq.delete();
    exq.push_back({3'd1, 9'h0});
    if (o == 0) begin
      exq.push_back(wcmd({eff, 1'b0}));
      if (eff[6:2] != 5'b10100) est = 1;
    end else if (o == 1 && al == 0) begin
      exq.push_back(wcmd({eff, 1'b1}));
    end else begin
      exq.push_back(wcmd({eff, 1'b0}));
      if (eff[6:2] != 5'b10100) begin est = 1; stopped = 1; end
      for (int i = al - 1; i >= 0 && !stopped; i--) begin
        ab = 8'(a >> (8 * i));
        exq.push_back(wcmd(ab));
        if (ab >= 8'hE0) begin est = 2; stopped = 1; end
      end
      if (!stopped && o == 1) begin
        exq.push_back({3'd2, 9'h0}); exq.push_back({3'd1, 9'h0});
        exq.push_back(wcmd({eff, 1'b1}));
      end
      if (!stopped && o == 2) foreach (wbuf[i]) exq.push_back(wcmd(wbuf[i]));
    end
    if (o == 1 && !stopped) for (int i = 0; i < n; i++) exq.push_back({3'd4, (i == n - 1), 8'h00});
    exq.push_back({3'd2, 9'h0});
    if (o == 2) foreach (wbuf[i]) wq.push_back(wbuf[i]);
    dev_alen = al;
    @(negedge clk);
    op = o; chip = c; mem_addr = a; addr_len = 3'(al); byte_cnt = 8'(n); fold_mask = m; start = 1;
    @(negedge clk); start = 0;
    while (!done) @(negedge clk);
    chk(status == 2'(est), req, "status", status, est);
    if (o == 2) chk(nack_cnt == 8'(exp_nack), req, "nack count", nack_cnt, exp_nack);
    chk(exq.size() == 0, req, "commands left unissued", exq.size(), 0);
    if (o == 1 && !stopped) begin
      chk(rdq.size() == rexp.size(), req, "read byte count", rdq.size(), rexp.size());
      foreach (rexp[i]) if (i < rdq.size()) chk(rdq[i] == rexp[i], req, "read byte", rdq[i], rexp[i]);
    end
    @(negedge clk);
    chk(!busy, "R12", "busy after done", busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !eng_cmd_valid && !done && !rd_valid && !wr_ready, "R12", "reset idle",
        {busy, eng_cmd_valid, done, rd_valid, wr_ready}, 0);
    rst_n = 1;
    @(negedge clk);
    // R10 recovery
    cur_req = "R10"; exq.delete(); exq.push_back({3'd0, 9'h0});
    init_req = 1; @(negedge clk); init_req = 0;
    chk(busy, "R10", "busy during recovery", busy, 1);
    begin
      bit saw_done = 0;
      while (busy) begin @(negedge clk); if (done) saw_done = 1; end
      chk(!saw_done, "R10", "no done pulse on recovery", saw_done, 0);
    end
    chk(exq.size() == 0, "R10", "recovery command issued", exq.size(), 0);
    // R1 probes
    wbuf.delete(); rexp.delete();
    run(0, 7'h50, 0, 0, 0, 0, 0, "R1");
    run(0, 7'h23, 0, 0, 0, 0, 0, "R1");
    // R8/R11 write then R5/R7 read back
    wbuf = '{8'hA1, 8'hB2, 8'hC3};
    run(2, 7'h50, 32'h10, 1, 3, 0, 0, "R8");
    rexp = '{8'hA1, 8'hB2, 8'hC3};
    run(1, 7'h50, 32'h10, 1, 3, 0, 0, "R5");
    // R11 single register write/read
    wbuf = '{8'h5A};
    run(2, 7'h50, 32'h40, 1, 1, 0, 0, "R11");
    rexp = '{8'h5A};
    run(1, 7'h50, 32'h40, 1, 1, 0, 0, "R7");
    // R6 current-address read (pointer now 0x41)
    rexp = '{8'h41 ^ 8'h3C};
    run(1, 7'h50, 0, 0, 1, 0, 0, "R6");
    // R8 partial data NACKs into protected window
    wbuf = '{8'h11, 8'h22, 8'h33, 8'h44};
    run(2, 7'h50, 32'hCE, 1, 4, 0, 2, "R8");
    rexp = '{8'h11, 8'h22, 8'hD0 ^ 8'h3C, 8'hD1 ^ 8'h3C};
    run(1, 7'h50, 32'hCE, 1, 4, 0, 0, "R8");
    // R2 absent device on read and write
    rexp.delete(); wbuf = '{8'h77};
    run(1, 7'h30, 32'h10, 1, 2, 0, 0, "R2");
    run(2, 7'h30, 32'h10, 1, 1, 0, 0, "R2");
    // R4 address NACK
    run(1, 7'h50, 32'hF0, 1, 1, 0, 0, "R4");
    run(2, 7'h50, 32'hE5, 1, 1, 0, 0, "R4");
    // R3 multi-byte address ordering
    wbuf.delete();
    run(2, 7'h50, 32'h11223344, 4, 0, 0, 0, "R3");
    rexp = '{8'h34 ^ 8'h3C};
    run(1, 7'h50, 32'h1234, 2, 1, 0, 0, "R3");
    // R9 fold upper address bits into device address
    wbuf = '{8'h99};
    run(2, 7'h50, 32'h2A7, 1, 1, 7'h03, 0, "R9");
    rexp = '{8'h99};
    run(1, 7'h52, 32'hA7, 1, 1, 0, 0, "R9");
    run(1, 7'h50, 32'h2A7, 1, 1, 7'h03, 0, "R9");
    rexp = '{8'hA7 ^ 8'h3C};
    run(1, 7'h50, 32'hA7, 1, 1, 0, 0, "R9");
    // R7 zero-count read still closes with STOP
    rexp.delete();
    run(1, 7'h50, 32'h20, 1, 0, 0, 0, "R7");
    finish_run();
  end
endmodule